// File: doc/BRIEF.md
# Compact instruction operand decoder

This block is purely combinational. It takes one 16-bit compact instruction word and turns it into up to three operands. Each operand comes out as a kind (register or immediate) and a value. Register and immediate indices are not stored in separate fields. Their upper digits share a single 5-bit field at bits 10..6 and are packed in base 3. The two low bits of each index sit in the bottom six bits of the word.

The value of the shared field decides which of two layouts the word uses.

- **Two-operand layout.** A caller-supplied format code picks how the two indices are presented. The choices are plain register pair, swapped pair, immediate then register, repeated source/destination, register plus immediate, and register plus bit-position.
- **Three-operand layout.** When the two-operand layout is invalid, the decoder falls back to this one. The top five bits of the word select an operation class, and that class fixes the kinds of the three operands.

Bit-position immediates are mapped to their real values. Any word that fits neither layout gives a low valid flag, and every other output is then zero.

The block has no state and no clock. Its outputs settle within the logic depth of one path: the shared-field split, the class lookup and the output gating. A pipeline places it between fetch and operand read.

Top module: `cod_operand_decoder`

## Requirements
- R1: With the shared field c = bits 10..6 below 27, the three indices are {c mod 3, bits 5..4}, {(c div 3) mod 3, bits 3..2} and {c div 9, bits 1..0} (upper digit in bits 3..2 of a 4-bit index). These are presented as opnd_a, opnd_b and opnd_c.
- R2: With c of 27 or more, and not the case (bit 5 set and c = 31), the word is two-operand. Let r = c - 27 + (5 if bit 5 is set). The first index is {r mod 3, bits 3..2} and the second is {r div 3, bits 1..0}. The two-operand layout takes priority over the fallback.
- R3: In the two-operand layout, fmt_sel selects how the outputs are filled. Kind codes are none = 0, register = 1, immediate = 2; unused slots are kind 0, value 0.
  - 0: a = first index (reg), b = second index (reg).
  - 1: a = second index (reg), b = first index (reg).
  - 2: a = first index as immediate, b = second index (reg).
  - 3: a = first index (reg), b = first index (reg), c = second index (reg).
  - 4: a = first index (reg), b = second index as immediate.
  - 5: a = first index (reg), b = bit-position of the second index (imm).
  - 6: as 3, but c = bit-position of the second index (imm).
- R4: fmt_sel = 7 is reserved. A word in the two-operand layout then decodes as invalid. A word in the fallback layout is unaffected by fmt_sel.
- R5: In the fallback layout, the operation code is bits 15..11. It is accepted only in 0x00..0x09 and 0x10..0x19; any other code is invalid.
- R6: Fallback operand kinds depend on the operation code:
  - 0x00, 0x01, 0x12, 0x13, 0x16: register, register, immediate.
  - 0x14, 0x15: register, register, bit-position immediate.
  - 0x17: immediate, register, register.
  - Every other accepted code: three registers.
- R7: The bit-position map sends code 0 to 32 and codes 1..8 to themselves. It sends 9 to 16, 10 to 24 and 11 to 32. Codes above 11 are invalid.
- R8: cls_id is 1 + the rank of the accepted fallback code in ascending order: codes 0x00..0x09 give 1..10 and codes 0x10..0x19 give 11..20. It is 0 for a two-operand or invalid word.
- R9: A word with bit 5 set and c = 31, an unaccepted fallback code, or a reserved format on a two-operand word gives dec_valid = 0. In every such case, all other outputs are 0.
- R10: is_three is 1 exactly for a valid fallback decode and 0 for a two-operand decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_word | input | 16 | Compact instruction word |
| fmt_sel | input | 3 | Two-operand presentation code (R3) |
| dec_valid | output | 1 | Word decoded successfully |
| is_three | output | 1 | Fallback three-operand layout used |
| cls_id | output | 5 | Fallback operation class identifier |
| kind_a | output | 2 | Kind of operand a |
| kind_b | output | 2 | Kind of operand b |
| kind_c | output | 2 | Kind of operand c |
| opnd_a | output | 6 | Operand a index or value |
| opnd_b | output | 6 | Operand b index or value |
| opnd_c | output | 6 | Operand c index or value |

## Verification
The block holds no state, so a wrong split of the shared field shows up in the very same evaluation. It appears as a misplaced upper digit in an operand index, or as a word claimed by the wrong layout. The hole at c = 31 with bit 5 set and the boundary at c = 27 are where the two layouts meet. A wrong choice between them flips is_three or dec_valid at once. Sweeping every 16-bit word exposes any wrongly mapped class code or bit-position code immediately at the outputs.

// File: rtl/cod_pkg.sv
package cod_pkg;
    localparam int WORD_W  = 16;
    localparam int CMB_W   = 5;
    localparam int IDX_W   = 4;
    localparam int VAL_W   = 6;
    localparam int CLS_W   = 5;
    localparam int KIND_W  = 2;
    localparam int FMT_W   = 3;
    localparam int LOW_W   = 11;
    localparam int PAIR_BASE = 27;
    localparam int PAIR_BIAS = 5;
    localparam int CMB_HOLE  = 31;
    localparam int MAX_REG   = 11;

    typedef enum logic [KIND_W-1:0] {
        KIND_NONE = 2'd0,
        KIND_REG  = 2'd1,
        KIND_IMM  = 2'd2
    } kind_e;

    typedef enum logic [FMT_W-1:0] {
        FMT_RR      = 3'd0,
        FMT_RR_SWAP = 3'd1,
        FMT_IR      = 3'd2,
        FMT_DUP_R   = 3'd3,
        FMT_RI      = 3'd4,
        FMT_RB      = 3'd5,
        FMT_DUP_B   = 3'd6,
        FMT_RSVD    = 3'd7
    } fmt_e;
endpackage

// File: rtl/cod_tern_split.sv
module cod_tern_split
    import cod_pkg::*;
(
    input  logic [LOW_W-1:0] low_bits,
    output logic             tern_ok,
    output logic [IDX_W-1:0] idx1,
    output logic [IDX_W-1:0] idx2,
    output logic [IDX_W-1:0] idx3
);
    logic [CMB_W-1:0] cmb;
    logic [CMB_W-1:0] rem9;
    logic [1:0]       d1, d2, d3;

    always_comb begin
        cmb     = low_bits[10:6];
        tern_ok = (int'(cmb) < PAIR_BASE);
        d3      = (cmb >= 5'd18) ? 2'd2 : (cmb >= 5'd9) ? 2'd1 : 2'd0;
        rem9    = cmb - 5'(9 * d3);
        d2      = (rem9 >= 5'd6) ? 2'd2 : (rem9 >= 5'd3) ? 2'd1 : 2'd0;
        d1      = 2'(rem9 - 5'(3 * d2));
        idx1    = {d1, low_bits[5:4]};
        idx2    = {d2, low_bits[3:2]};
        idx3    = {d3, low_bits[1:0]};
    end
endmodule

// File: rtl/cod_pair_split.sv
module cod_pair_split
    import cod_pkg::*;
(
    input  logic [LOW_W-1:0] low_bits,
    output logic             pair_ok,
    output logic [IDX_W-1:0] idx1,
    output logic [IDX_W-1:0] idx2
);
    logic [CMB_W-1:0] cmb;
    logic [5:0]       rel;
    logic [1:0]       d1, d2;
    logic             in_hole;

    always_comb begin
        cmb     = low_bits[10:6];
        in_hole = low_bits[5] && (int'(cmb) == CMB_HOLE);
        pair_ok = (int'(cmb) >= PAIR_BASE) && !in_hole;
        rel     = {1'b0, cmb} + (low_bits[5] ? 6'(PAIR_BIAS) : 6'd0) - 6'(PAIR_BASE);
        d2      = (rel >= 6'd6) ? 2'd2 : (rel >= 6'd3) ? 2'd1 : 2'd0;
        d1      = 2'(rel - 6'(3 * d2));
        idx1    = {d1, low_bits[3:2]};
        idx2    = {d2, low_bits[1:0]};
    end
endmodule

// File: rtl/cod_bitpos_map.sv
module cod_bitpos_map
    import cod_pkg::*;
(
    input  logic [IDX_W-1:0] code,
    output logic             map_ok,
    output logic [VAL_W-1:0] value
);
    always_comb begin
        map_ok = 1'b1;
        unique case (code)
            4'd0:                                     value = 6'd32;
            4'd1, 4'd2, 4'd3, 4'd4,
            4'd5, 4'd6, 4'd7, 4'd8:                   value = {2'b00, code};
            4'd9:                                     value = 6'd16;
            4'd10:                                    value = 6'd24;
            4'd11:                                    value = 6'd32;
            default: begin
                map_ok = 1'b0;
                value  = '0;
            end
        endcase
    end
endmodule

// File: rtl/cod_operand_decoder.sv
module cod_operand_decoder
    import cod_pkg::*;
(
    input  logic [WORD_W-1:0] insn_word,
    input  logic [FMT_W-1:0]  fmt_sel,
    output logic              dec_valid,
    output logic              is_three,
    output logic [CLS_W-1:0]  cls_id,
    output logic [KIND_W-1:0] kind_a,
    output logic [KIND_W-1:0] kind_b,
    output logic [KIND_W-1:0] kind_c,
    output logic [VAL_W-1:0]  opnd_a,
    output logic [VAL_W-1:0]  opnd_b,
    output logic [VAL_W-1:0]  opnd_c
);
    localparam int N_SPLIT = 2;

    logic             pair_ok, tern_ok;
    logic [IDX_W-1:0] p1, p2, t1, t2, t3;
    logic [IDX_W-1:0] bp_code [N_SPLIT];
    logic             bp_ok   [N_SPLIT];
    logic [VAL_W-1:0] bp_val  [N_SPLIT];
    logic [CMB_W-1:0] opc;
    logic [CLS_W-1:0] fb_id;

    logic             c_valid, c_three;
    logic [CLS_W-1:0] c_cls;
    kind_e            c_ka, c_kb, c_kc;
    logic [VAL_W-1:0] c_a, c_b, c_c;

    cod_pair_split u_pair (
        .low_bits (insn_word[LOW_W-1:0]),
        .pair_ok  (pair_ok),
        .idx1     (p1),
        .idx2     (p2)
    );

    cod_tern_split u_tern (
        .low_bits (insn_word[LOW_W-1:0]),
        .tern_ok  (tern_ok),
        .idx1     (t1),
        .idx2     (t2),
        .idx3     (t3)
    );

    assign bp_code[0] = p2;
    assign bp_code[1] = t3;

    generate
        for (genvar gi = 0; gi < N_SPLIT; gi++) begin : g_bitpos
            cod_bitpos_map u_map (
                .code   (bp_code[gi]),
                .map_ok (bp_ok[gi]),
                .value  (bp_val[gi])
            );
        end
    endgenerate

    // Fallback class lookup: rank of the operation code among accepted codes.
    always_comb begin
        opc = insn_word[15:11];
        if (opc <= 5'h09)
            fb_id = opc + 5'd1;
        else if (opc >= 5'h10 && opc <= 5'h19)
            fb_id = opc - 5'd5;
        else
            fb_id = '0;
    end

    // Candidate operand assembly.
    always_comb begin
        c_valid = 1'b0;
        c_three = 1'b0;
        c_cls   = '0;
        c_ka    = KIND_NONE;
        c_kb    = KIND_NONE;
        c_kc    = KIND_NONE;
        c_a     = '0;
        c_b     = '0;
        c_c     = '0;
        if (pair_ok) begin
            c_valid = 1'b1;
            unique case (fmt_e'(fmt_sel))
                FMT_RR: begin
                    c_ka = KIND_REG; c_a = {2'b00, p1};
                    c_kb = KIND_REG; c_b = {2'b00, p2};
                end
                FMT_RR_SWAP: begin
                    c_ka = KIND_REG; c_a = {2'b00, p2};
                    c_kb = KIND_REG; c_b = {2'b00, p1};
                end
                FMT_IR: begin
                    c_ka = KIND_IMM; c_a = {2'b00, p1};
                    c_kb = KIND_REG; c_b = {2'b00, p2};
                end
                FMT_DUP_R: begin
                    c_ka = KIND_REG; c_a = {2'b00, p1};
                    c_kb = KIND_REG; c_b = {2'b00, p1};
                    c_kc = KIND_REG; c_c = {2'b00, p2};
                end
                FMT_RI: begin
                    c_ka = KIND_REG; c_a = {2'b00, p1};
                    c_kb = KIND_IMM; c_b = {2'b00, p2};
                end
                FMT_RB: begin
                    c_ka = KIND_REG; c_a = {2'b00, p1};
                    c_kb = KIND_IMM; c_b = bp_val[0];
                    c_valid = bp_ok[0];
                end
                FMT_DUP_B: begin
                    c_ka = KIND_REG; c_a = {2'b00, p1};
                    c_kb = KIND_REG; c_b = {2'b00, p1};
                    c_kc = KIND_IMM; c_c = bp_val[0];
                    c_valid = bp_ok[0];
                end
                FMT_RSVD: c_valid = 1'b0;
            endcase
        end else if (tern_ok && fb_id != '0) begin
            c_valid = 1'b1;
            c_three = 1'b1;
            c_cls   = fb_id;
            c_ka    = KIND_REG; c_a = {2'b00, t1};
            c_kb    = KIND_REG; c_b = {2'b00, t2};
            c_kc    = KIND_REG; c_c = {2'b00, t3};
            case (opc)
                5'h00, 5'h01, 5'h12, 5'h13, 5'h16: c_kc = KIND_IMM;
                5'h14, 5'h15: begin
                    c_kc    = KIND_IMM;
                    c_c     = bp_val[1];
                    c_valid = bp_ok[1];
                end
                5'h17: c_ka = KIND_IMM;
                default: ;
            endcase
        end
    end

    // Output gating: an invalid decode presents all zeros.
    always_comb begin
        dec_valid = c_valid;
        is_three  = c_valid & c_three;
        cls_id    = c_valid ? c_cls : '0;
        kind_a    = c_valid ? c_ka  : KIND_NONE;
        kind_b    = c_valid ? c_kb  : KIND_NONE;
        kind_c    = c_valid ? c_kc  : KIND_NONE;
        opnd_a    = c_valid ? c_a   : '0;
        opnd_b    = c_valid ? c_b   : '0;
        opnd_c    = c_valid ? c_c   : '0;
    end

    always_comb begin
        // R9
        zero_when_bad_chk: assert (dec_valid || ({is_three, cls_id, kind_a, kind_b, kind_c,
                                                  opnd_a, opnd_b, opnd_c} == '0));
        // R10
        three_low_cmb_chk: assert (!is_three || int'(insn_word[10:6]) < PAIR_BASE);
        // R2
        pair_high_cmb_chk: assert (!(dec_valid && !is_three) || int'(insn_word[10:6]) >= PAIR_BASE);
        // R8
        cls_with_three_chk: assert ((cls_id != '0) == is_three);
        // R1
        reg_in_range_chk: assert ((kind_a != KIND_REG || int'(opnd_a) <= MAX_REG) &&
                                  (kind_b != KIND_REG || int'(opnd_b) <= MAX_REG) &&
                                  (kind_c != KIND_REG || int'(opnd_c) <= MAX_REG));
    end
endmodule

// File: tb/sim_cod_operand_decoder.sv
module sim_cod_operand_decoder;
    logic        clk = 1'b0;
    logic [15:0] w = '0;
    logic [2:0]  f = '0;
    logic        dec_valid, is_three;
    logic [4:0]  cls_id;
    logic [1:0]  kind_a, kind_b, kind_c;
    logic [5:0]  opnd_a, opnd_b, opnd_c;
    int          n_run = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    cod_operand_decoder u0 (
        .insn_word (w),
        .fmt_sel   (f),
        .dec_valid (dec_valid),
        .is_three  (is_three),
        .cls_id    (cls_id),
        .kind_a    (kind_a),
        .kind_b    (kind_b),
        .kind_c    (kind_c),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .opnd_c    (opnd_c)
    );

    function automatic int bitpos(input int code);
        if (code == 0 || code == 11) return 32;
        if (code <= 8) return code;
        if (code == 9) return 16;
        return 24;
    endfunction

    function automatic logic [30:0] pack(input bit v, input bit th, input int id,
                                         input int ka, input int kb, input int kc,
                                         input int a, input int b, input int c);
        if (!v) return '0;
        return {v, th, 5'(id), 2'(ka), 2'(kb), 2'(kc), 6'(a), 6'(b), 6'(c)};
    endfunction

    function automatic logic [30:0] ref_dec(input logic [15:0] x, input logic [2:0] fs);
        int c   = int'(x[10:6]);
        int opc = int'(x[15:11]);
        int lo1 = int'(x[5:4]);
        int lo2 = int'(x[3:2]);
        int lo3 = int'(x[1:0]);
        if (c >= 27 && !(x[5] && c == 31)) begin
            int r  = c - 27 + (x[5] ? 5 : 0);
            int i1 = (r % 3) * 4 + lo2;
            int i2 = (r / 3) * 4 + lo3;
            case (fs)
                3'd0: return pack(1, 0, 0, 1, 1, 0, i1, i2, 0);
                3'd1: return pack(1, 0, 0, 1, 1, 0, i2, i1, 0);
                3'd2: return pack(1, 0, 0, 2, 1, 0, i1, i2, 0);
                3'd3: return pack(1, 0, 0, 1, 1, 1, i1, i1, i2);
                3'd4: return pack(1, 0, 0, 1, 2, 0, i1, i2, 0);
                3'd5: return pack(1, 0, 0, 1, 2, 0, i1, bitpos(i2), 0);
                3'd6: return pack(1, 0, 0, 1, 1, 2, i1, i1, bitpos(i2));
                default: return '0;
            endcase
        end
        if (c < 27) begin
            int i1 = (c % 3) * 4 + lo1;
            int i2 = ((c / 3) % 3) * 4 + lo2;
            int i3 = (c / 9) * 4 + lo3;
            int id;
            if (opc <= 9) id = opc + 1;
            else if (opc >= 16 && opc <= 25) id = opc - 5;
            else return '0;
            if (opc == 0 || opc == 1 || opc == 18 || opc == 19 || opc == 22)
                return pack(1, 1, id, 1, 1, 2, i1, i2, i3);
            if (opc == 20 || opc == 21)
                return pack(1, 1, id, 1, 1, 2, i1, i2, bitpos(i3));
            if (opc == 23)
                return pack(1, 1, id, 2, 1, 1, i1, i2, i3);
            return pack(1, 1, id, 1, 1, 1, i1, i2, i3);
        end
        return '0;
    endfunction

    function automatic logic [15:0] mk(input int opc, input int c, input int lo);
        return {5'(opc), 5'(c), 6'(lo)};
    endfunction

    task automatic check_vec(input logic [15:0] x, input logic [2:0] fs, input string tag);
        logic [30:0] exp_v, act_v;
        @(posedge clk);
        w <= x;
        f <= fs;
        @(negedge clk);
        exp_v = ref_dec(x, fs);
        act_v = {dec_valid, is_three, cls_id, kind_a, kind_b, kind_c, opnd_a, opnd_b, opnd_c};
        n_run++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s word=%h fmt=%0d actual=%h expected=%h", tag, x, fs, act_v, exp_v);
        end
    endtask

    function automatic string tag_of(input logic [15:0] x, input logic [2:0] fs);
        logic [30:0] e = ref_dec(x, fs);
        if (!e[30]) return "R9";
        if (e[29]) return "R6";
        return "R3";
    endfunction

    initial begin
        void'($urandom(32'h5eed_c0de));
        // R1 idle word: store class, all indices zero
        check_vec(16'h0000, 3'd0, "R1");
        check_vec(mk(2, 26, 6'h3f), 3'd0, "R1");
        check_vec(mk(7, 13, 6'h1b), 3'd4, "R1");
        // R2 boundary and biased values
        check_vec(mk(0, 27, 6'h0f), 3'd0, "R2");
        check_vec(mk(0, 31, 6'h06), 3'd0, "R2");
        check_vec(mk(0, 30, 6'h2d), 3'd0, "R2");
        check_vec(mk(0, 27, 6'h20), 3'd0, "R2");
        // R3 every presentation code
        for (int k = 0; k < 7; k++) check_vec(mk(3, 29, 6'h29), 3'(k), "R3");
        // R4 reserved format on a two-operand word and on a fallback word
        check_vec(mk(1, 28, 6'h05), 3'd7, "R4");
        check_vec(mk(2, 4, 6'h05), 3'd7, "R4");
        // R5 rejected fallback codes
        check_vec(mk(10, 5, 6'h00), 3'd0, "R5");
        check_vec(mk(31, 5, 6'h00), 3'd0, "R5");
        // R6 kinds per class
        check_vec(mk(23, 8, 6'h12), 3'd0, "R6");
        check_vec(mk(22, 8, 6'h12), 3'd0, "R6");
        // R7 bit-position codes
        check_vec(mk(20, 0, 6'h00), 3'd0, "R7");
        check_vec(mk(21, 9, 6'h01), 3'd0, "R7");
        check_vec(mk(20, 18, 6'h01), 3'd0, "R7");
        check_vec(mk(21, 18, 6'h02), 3'd0, "R7");
        check_vec(mk(20, 18, 6'h03), 3'd0, "R7");
        check_vec(mk(0, 31, 6'h03), 3'd5, "R7");
        // R8 class identifier at both ends of the second range
        check_vec(mk(16, 1, 6'h00), 3'd0, "R8");
        check_vec(mk(25, 1, 6'h00), 3'd0, "R8");
        // R9 hole at c = 31 with bit 5 set
        check_vec(mk(4, 31, 6'h3f), 3'd0, "R9");
        // R10 layout flag
        check_vec(mk(4, 27, 6'h00), 3'd2, "R10");
        // full sweep with random presentation codes
        for (int i = 0; i < 65536; i++) begin
            logic [2:0] rf = 3'($urandom % 8);
            check_vec(16'(i), rf, tag_of(16'(i), rf));
        end
        for (int i = 0; i < 2000; i++) begin
            logic [15:0] rw = 16'($urandom);
            logic [2:0]  rf = 3'($urandom);
            check_vec(rw, rf, tag_of(rw, rf));
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule